// File: doc/BRIEF.md
# Static Memory Write-Cycle Sequencer

This block generates the pin waveform of a single write to an asynchronous static memory. A requester hands over one write at a time (address, data, byte enables and the index of the target chip select) through a ready/valid handshake. The block then drives the address, data and active-low byte strobes, raises the data output enable for the whole access, and places an active-low write strobe and the active-low select of the chosen device inside that access. All five timing values are held separately for each chip select and are counted in whole clocks.

For each device, software gives the write-strobe setup and pulse, the chip-select setup and pulse, and the total access length. It does not give hold times. Each hold is whatever the total leaves after its own setup and pulse, so the two strobes have independent holds inside one common access length. A pulse of zero is not legal: it is run as one clock and raises a sticky error flag. If a setup plus its pulse is longer than the programmed total, the access is stretched to fit and that hold becomes zero.

A one-clock done pulse marks the last clock of each access. When the next request to the same device is already waiting on that clock, it starts on the following clock with no idle clock in between. With zero setup and zero hold, the strobes therefore stay low across the joined accesses. A request to a different device waits for one idle clock, during which every strobe is high.

Top module: `sram_wr_seq`

## Requirements
- R1: Access clocks are numbered k = 0 to T-1, where k = 0 is the clock after the request is accepted. The write strobe `mem_we_n` is low exactly for k in [WS, WS+WP'), where WS is the write-strobe setup and WP' is max(write-strobe pulse, 1). It is high at every other time.
- R2: Only the select line of the accepted index, `mem_cs_n[idx]`, goes low, exactly for k in [CS, CS+CP'), where CP' is max(chip-select pulse, 1). This window is independent of the write-strobe values. Every other select line stays high.
- R3: The access length is T = max(C, WS+WP', CS+CP'), where C is the programmed total. The write-strobe hold is T-WS-WP' and the chip-select hold is T-CS-CP', so neither hold is ever negative.
- R4: For all T clocks of an access, `mem_data_oe` is 1, `mem_addr` and `mem_data` hold the request values, and `mem_be_n` holds the bitwise inverse of the request byte enables. Outside an access, `mem_data_oe` is 0 and `mem_be_n` is all ones.
- R5: A request is accepted on a clock edge where both `req_valid` and `req_ready` are 1. `req_ready` is 1 whenever no access is running. `wr_done` is 1 on clock k = T-1 only.
- R6: On the done clock, `req_ready` is 1 only if `req_cs` equals the running index. A request accepted then has its k = 0 on the very next clock, so strobes with zero setup and zero hold stay low across the two accesses. A request to another index waits for one clock with every strobe high.
- R7: A pulse field of zero behaves as a pulse of one clock. `cfg_err` becomes 1 from k = 0 of any accepted request whose write-strobe pulse or chip-select pulse is zero, and it stays 1 until reset.
- R8: A synchronous active-high reset puts the block in this state: `mem_we_n` = 1, all `mem_cs_n` = 1, `mem_data_oe` = 0, `wr_done` = 0, `cfg_err` = 0, `req_ready` = 1.
- R9: At most one select line is low on any clock.
- R10: The timing field for chip select i sits at bits [i*4 +: 4] of each timing input, with 4 bits per field by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request can be accepted on this edge |
| req_cs | input | CSW | Target chip-select index |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| t_we_setup | input | NUM_CS*TW | Write-strobe setup per chip select |
| t_we_pulse | input | NUM_CS*TW | Write-strobe pulse per chip select |
| t_cs_setup | input | NUM_CS*TW | Chip-select setup per chip select |
| t_cs_pulse | input | NUM_CS*TW | Chip-select pulse per chip select |
| t_cycle | input | NUM_CS*TW | Total access length per chip select |
| mem_addr | output | AW | Address bus |
| mem_data | output | DW | Data bus value |
| mem_data_oe | output | 1 | Data bus output enable |
| mem_be_n | output | DW/8 | Byte strobes, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_cs_n | output | NUM_CS | Chip selects, active low |
| wr_done | output | 1 | Last clock of the access |
| cfg_err | output | 1 | Sticky zero-pulse flag |

## Verification
Two functions can fall in the same clock: the done clock that ends one access and the acceptance of the next request. The bench keeps `req_valid` high through the done clock, first with the same index and then with a different one. A same-index request must be accepted on that clock, and its k = 0 must follow at once with the write strobe still low. A different-index request must see `req_ready` low on the done clock and then one clock with every strobe high. An exhaustive sweep of setups, pulses (including zero) and totals on a small field width is judged clock by clock against windows that the bench computes arithmetically.

// File: rtl/sws_pkg.sv
package sws_pkg;
  parameter int TW = 4;
  localparam int CW = TW + 2;

  typedef logic [TW-1:0] tval_t;
  typedef logic [CW-1:0] cnt_t;

  typedef struct packed {
    cnt_t we_beg;
    cnt_t we_end;
    cnt_t cs_beg;
    cnt_t cs_end;
    cnt_t last;
    logic bad;
  } plan_t;

  function automatic cnt_t widen(input tval_t v);
    return cnt_t'(v);
  endfunction

  function automatic cnt_t pulse_eff(input tval_t v);
    return (v == '0) ? cnt_t'(1) : cnt_t'(v);
  endfunction

  function automatic plan_t make_plan(input tval_t ws, input tval_t wp,
                                      input tval_t cs, input tval_t cp,
                                      input tval_t cyc);
    plan_t p;
    cnt_t  total;
    p.we_beg = widen(ws);
    p.we_end = widen(ws) + pulse_eff(wp);
    p.cs_beg = widen(cs);
    p.cs_end = widen(cs) + pulse_eff(cp);
    total    = widen(cyc);
    if (p.we_end > total) total = p.we_end;
    if (p.cs_end > total) total = p.cs_end;
    p.last   = total - cnt_t'(1);
    p.bad    = (wp == '0) || (cp == '0);
    return p;
  endfunction
endpackage

// File: rtl/sws_plan_sel.sv
module sws_plan_sel
  import sws_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CSW    = 2
) (
  input  logic [NUM_CS*TW-1:0] t_we_setup,
  input  logic [NUM_CS*TW-1:0] t_we_pulse,
  input  logic [NUM_CS*TW-1:0] t_cs_setup,
  input  logic [NUM_CS*TW-1:0] t_cs_pulse,
  input  logic [NUM_CS*TW-1:0] t_cycle,
  input  logic [CSW-1:0]       sel,
  output plan_t                plan
);
  plan_t plans [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign plans[g] = make_plan(t_we_setup[g*TW +: TW], t_we_pulse[g*TW +: TW],
                                t_cs_setup[g*TW +: TW], t_cs_pulse[g*TW +: TW],
                                t_cycle[g*TW +: TW]);
  end

  assign plan = plans[sel];
endmodule

// File: rtl/sws_ctrl.sv
module sws_ctrl
  import sws_pkg::*;
#(
  parameter int CSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [CSW-1:0] req_cs,
  input  plan_t          plan_in,
  output logic           req_ready,
  output logic           accept,
  output logic           n_busy,
  output cnt_t           n_cnt,
  output plan_t          n_plan,
  output logic [CSW-1:0] n_cs,
  output logic           cfg_err
);
  logic           busy_q;
  cnt_t           cnt_q;
  plan_t          plan_q;
  logic [CSW-1:0] cs_q;
  logic           err_q;
  logic           at_end;

  assign at_end    = busy_q && (cnt_q == plan_q.last);
  assign req_ready = !busy_q || (at_end && (req_cs == cs_q));
  assign accept    = req_valid && req_ready;
  assign cfg_err   = err_q;

  always_comb begin
    n_busy = busy_q;
    n_cnt  = cnt_q;
    n_plan = plan_q;
    n_cs   = cs_q;
    if (accept) begin
      n_busy = 1'b1;
      n_cnt  = '0;
      n_plan = plan_in;
      n_cs   = req_cs;
    end else if (at_end) begin
      n_busy = 1'b0;
      n_cnt  = '0;
    end else if (busy_q) begin
      n_cnt  = cnt_q + cnt_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      plan_q <= '0;
      cs_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= n_busy;
      cnt_q  <= n_cnt;
      plan_q <= n_plan;
      cs_q   <= n_cs;
      err_q  <= err_q | (accept & plan_in.bad);
    end
  end

  // R5: an idle sequencer always offers ready
  a_r5_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> req_ready);

  // R5: an accepted request begins at clock zero of its access
  a_r5_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy_q && cnt_q == '0));

  // R3: the clock counter never passes the stretched length
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= plan_q.last));

  // R7: the error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/sws_pins.sv
module sws_pins
  import sws_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CSW    = 2,
  parameter int AW     = 24,
  parameter int DW     = 32,
  parameter int BEW    = DW / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic [BEW-1:0]    req_be,
  input  logic              n_busy,
  input  cnt_t              n_cnt,
  input  cnt_t              we_beg,
  input  cnt_t              we_end,
  input  cnt_t              cs_beg,
  input  cnt_t              cs_end,
  input  cnt_t              last,
  input  logic [CSW-1:0]    n_cs,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_data,
  output logic              mem_data_oe,
  output logic [BEW-1:0]    mem_be_n,
  output logic              mem_we_n,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              wr_done
);
  logic we_win;
  logic cs_win;

  assign we_win = n_busy && (n_cnt >= we_beg) && (n_cnt < we_end);
  assign cs_win = n_busy && (n_cnt >= cs_beg) && (n_cnt < cs_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr    <= '0;
      mem_data    <= '0;
      mem_data_oe <= 1'b0;
      mem_be_n    <= '1;
      mem_we_n    <= 1'b1;
      wr_done     <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_data <= req_data;
        mem_be_n <= ~req_be;
      end else if (!n_busy) begin
        mem_be_n <= '1;
      end
      mem_data_oe <= n_busy;
      mem_we_n    <= !we_win;
      wr_done     <= n_busy && (n_cnt == last);
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) mem_cs_n[g] <= 1'b1;
      else     mem_cs_n[g] <= !(cs_win && (n_cs == CSW'(g)));
    end
  end

  // R4: bus values do not move inside an access
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_data_oe && !wr_done) |=> ($stable(mem_addr) && $stable(mem_data) && $stable(mem_be_n)));

  // R4 / R6: strobes are high whenever no access drives the bus
  a_r6_idle_strobes_high: assert property (@(posedge clk) disable iff (rst)
    !mem_data_oe |-> (mem_we_n && (&mem_cs_n) && (&mem_be_n)));

  // R5: done only appears inside an access
  a_r5_done_in_access: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> mem_data_oe);

  // R9: never more than one device selected
  a_r9_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sws_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int AW     = 24,
  parameter int DW     = 32,
  localparam int BEW   = DW / 8,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CSW-1:0]       req_cs,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_data,
  input  logic [BEW-1:0]       req_be,
  input  logic [NUM_CS*TW-1:0] t_we_setup,
  input  logic [NUM_CS*TW-1:0] t_we_pulse,
  input  logic [NUM_CS*TW-1:0] t_cs_setup,
  input  logic [NUM_CS*TW-1:0] t_cs_pulse,
  input  logic [NUM_CS*TW-1:0] t_cycle,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_data,
  output logic                 mem_data_oe,
  output logic [BEW-1:0]       mem_be_n,
  output logic                 mem_we_n,
  output logic [NUM_CS-1:0]    mem_cs_n,
  output logic                 wr_done,
  output logic                 cfg_err
);
  plan_t          sel_plan;
  plan_t          n_plan;
  logic           accept;
  logic           n_busy;
  cnt_t           n_cnt;
  logic [CSW-1:0] n_cs;

  sws_plan_sel #(.NUM_CS(NUM_CS), .CSW(CSW)) u_sel (
    .t_we_setup (t_we_setup),
    .t_we_pulse (t_we_pulse),
    .t_cs_setup (t_cs_setup),
    .t_cs_pulse (t_cs_pulse),
    .t_cycle    (t_cycle),
    .sel        (req_cs),
    .plan       (sel_plan)
  );

  sws_ctrl #(.CSW(CSW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_cs    (req_cs),
    .plan_in   (sel_plan),
    .req_ready (req_ready),
    .accept    (accept),
    .n_busy    (n_busy),
    .n_cnt     (n_cnt),
    .n_plan    (n_plan),
    .n_cs      (n_cs),
    .cfg_err   (cfg_err)
  );

  sws_pins #(.NUM_CS(NUM_CS), .CSW(CSW), .AW(AW), .DW(DW), .BEW(BEW)) u_pins (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .req_be      (req_be),
    .n_busy      (n_busy),
    .n_cnt       (n_cnt),
    .we_beg      (n_plan.we_beg),
    .we_end      (n_plan.we_end),
    .cs_beg      (n_plan.cs_beg),
    .cs_end      (n_plan.cs_end),
    .last        (n_plan.last),
    .n_cs        (n_cs),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .mem_data_oe (mem_data_oe),
    .mem_be_n    (mem_be_n),
    .mem_we_n    (mem_we_n),
    .mem_cs_n    (mem_cs_n),
    .wr_done     (wr_done)
  );
endmodule

// File: tb/sram_wr_seq_tb_top.sv
`timescale 1ns/1ps
module sram_wr_seq_tb_top;
  localparam int NCS = 4;
  localparam int FW  = 4;
  localparam int AW  = 24;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_cs = '0;
  logic [AW-1:0]     req_addr = '0;
  logic [DW-1:0]     req_data = '0;
  logic [3:0]        req_be = '0;
  logic [NCS*FW-1:0] t_we_setup = '0, t_we_pulse = '0, t_cs_setup = '0;
  logic [NCS*FW-1:0] t_cs_pulse = '0, t_cycle = '0;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_data;
  logic              mem_data_oe;
  logic [3:0]        mem_be_n;
  logic              mem_we_n;
  logic [NCS-1:0]    mem_cs_n;
  logic              wr_done;
  logic              cfg_err;

  sram_wr_seq #(.NUM_CS(NCS), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs(req_cs), .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .t_we_setup(t_we_setup), .t_we_pulse(t_we_pulse), .t_cs_setup(t_cs_setup),
    .t_cs_pulse(t_cs_pulse), .t_cycle(t_cycle), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_data_oe(mem_data_oe), .mem_be_n(mem_be_n),
    .mem_we_n(mem_we_n), .mem_cs_n(mem_cs_n), .wr_done(wr_done), .cfg_err(cfg_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // arithmetic reference of the access currently on the pins
  bit          m_busy = 0, m_acc = 0, m_err = 0, m_run = 0;
  int          m_k, m_T, m_ws, m_we, m_cs0, m_ce, m_cs;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [3:0]    m_be;

  function automatic int fld(input logic [NCS*FW-1:0] v, input int i);
    return int'(v[i*FW +: FW]);
  endfunction

  function automatic bit exp_ready();
    return !m_busy || ((m_k == m_T - 1) && (int'(req_cs) == m_cs));
  endfunction

  always @(posedge clk) begin
    m_acc = 0;
    if (rst) begin
      m_busy = 0; m_err = 0;
    end else begin
      if (req_valid && exp_ready()) begin
        int c, wp, cp;
        c     = int'(req_cs);
        wp    = (fld(t_we_pulse, c) == 0) ? 1 : fld(t_we_pulse, c);
        cp    = (fld(t_cs_pulse, c) == 0) ? 1 : fld(t_cs_pulse, c);
        if (fld(t_we_pulse, c) == 0 || fld(t_cs_pulse, c) == 0) m_err = 1;
        m_ws  = fld(t_we_setup, c);  m_we = m_ws + wp;
        m_cs0 = fld(t_cs_setup, c);  m_ce = m_cs0 + cp;
        m_T   = fld(t_cycle, c);
        if (m_we > m_T) m_T = m_we;
        if (m_ce > m_T) m_T = m_ce;
        m_cs = c; m_addr = req_addr; m_data = req_data; m_be = req_be;
        m_busy = 1; m_k = 0; m_acc = 1;
      end else if (m_busy && m_k == m_T - 1) begin
        m_busy = 0;
      end else if (m_busy) begin
        m_k++;
      end
    end
  end

  always @(negedge clk) begin
    if (m_run) begin
      logic [NCS-1:0] ecs;
      bit ewe;
      ewe = !(m_busy && m_k >= m_ws && m_k < m_we);
      ecs = '1;
      if (m_busy && m_k >= m_cs0 && m_k < m_ce) ecs[m_cs] = 1'b0;
      check(req_ready == exp_ready(), "R5 R6", "req_ready", req_ready, exp_ready());
      check(mem_we_n == ewe, "R1", "we_n", mem_we_n, ewe);
      check(mem_cs_n == ecs, "R2", "cs_n", mem_cs_n, ecs);
      check($countones(~mem_cs_n) <= 1, "R9", "selects low", $countones(~mem_cs_n), 1);
      check(mem_data_oe == m_busy, "R4", "data_oe", mem_data_oe, m_busy);
      check(wr_done == (m_busy && m_k == m_T - 1), "R3", "done/length", wr_done,
            m_busy && m_k == m_T - 1);
      check(cfg_err == m_err, "R7", "cfg_err", cfg_err, m_err);
      if (m_busy) begin
        check(mem_addr == m_addr, "R4", "addr", mem_addr, m_addr);
        check(mem_data == m_data, "R4", "data", mem_data, m_data);
        check(mem_be_n == ~m_be, "R4", "be_n", mem_be_n, ~m_be);
      end else begin
        check(mem_be_n == 4'hf, "R4", "be_n idle", mem_be_n, 4'hf);
      end
    end
  end

  task automatic set_tm(input int c, input int ws, input int wp, input int cs,
                        input int cp, input int cy);
    t_we_setup[c*FW +: FW] = FW'(ws);
    t_we_pulse[c*FW +: FW] = FW'(wp);
    t_cs_setup[c*FW +: FW] = FW'(cs);
    t_cs_pulse[c*FW +: FW] = FW'(cp);
    t_cycle[c*FW +: FW]    = FW'(cy);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  // present a request and return just after the edge that takes it
  task automatic send(input int c, input int a);
    req_valid = 1'b1;
    req_cs    = 2'(c);
    req_addr  = AW'(a * 37 + 5);
    req_data  = DW'(a) * 32'h9e37_79b1;
    req_be    = 4'(a + 1);
    do begin @(posedge clk); #1; end while (!m_acc);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL R5 watchdog: cycles=%0d expected < %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    check(mem_we_n == 1'b1, "R8", "we_n", mem_we_n, 1);
    check(mem_cs_n == '1, "R8", "cs_n", mem_cs_n, 4'hf);
    check(mem_data_oe == 1'b0, "R8", "oe", mem_data_oe, 0);
    check(wr_done == 1'b0, "R8", "done", wr_done, 0);
    check(cfg_err == 1'b0, "R8", "cfg_err", cfg_err, 0);
    check(req_ready == 1'b1, "R8", "ready", req_ready, 1);
    m_run = 1;

    // R10: distinct timings per select, each from its own field
    set_tm(0, 1, 2, 0, 4, 6);
    set_tm(1, 0, 1, 2, 1, 2);
    set_tm(2, 3, 3, 1, 5, 0);
    set_tm(3, 2, 1, 2, 1, 15);
    for (int i = 0; i < 8; i++) begin
      wait_idle(); send(i % NCS, i); req_valid = 1'b0;
    end
    wait_idle();
    check(cfg_err == 1'b0, "R7", "no zero pulse yet", cfg_err, 0);

    // R6: same select joined back to back, zero setup and hold
    set_tm(1, 0, 3, 0, 3, 3);
    wait_idle();
    send(1, 20); send(1, 21); send(1, 22);
    req_valid = 1'b0;
    while (m_busy) begin
      @(negedge clk);
      if (m_busy) begin
        check(mem_we_n == 1'b0, "R6", "we_n held low", mem_we_n, 0);
        check(mem_cs_n[1] == 1'b0, "R6", "cs_n held low", mem_cs_n[1], 0);
      end
    end

    // R6: different select must not join
    set_tm(2, 0, 3, 0, 3, 3);
    wait_idle();
    send(1, 30);
    req_valid = 1'b1; req_cs = 2'd2; req_addr = 24'h123456;
    while (!(m_busy && m_k == m_T - 1)) @(negedge clk);
    check(req_ready == 1'b0, "R6", "ready on done, other cs", req_ready, 0);
    @(negedge clk);
    check(mem_we_n == 1'b1 && mem_cs_n == '1, "R6", "idle gap strobes",
          {mem_we_n, mem_cs_n}, 5'h1f);
    do begin @(posedge clk); #1; end while (!m_acc);
    req_valid = 1'b0;

    // R1 R2 R3 R7: sweep setups, pulses (zero included) and totals
    for (int ws = 0; ws < 4; ws++)
      for (int wp = 0; wp < 4; wp++)
        for (int cs = 0; cs < 4; cs++)
          for (int cp = 0; cp < 4; cp++)
            for (int cy = 0; cy < 4; cy++) begin
              int c;
              c = (ws + wp + cs + cp + cy) % NCS;
              wait_idle();
              set_tm(c, ws, wp, cs, cp, cy * 4 + (cy == 3 ? 1 : 0));
              send(c, ws * 64 + wp * 16 + cs * 4 + cp);
              req_valid = 1'b0;
            end
    wait_idle();
    check(cfg_err == 1'b1, "R7", "sticky after zero pulse", cfg_err, 1);
    @(negedge clk);
    m_run = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule